// File: doc/BRIEF.md
# Shared Control Register Bank with Single-Bit Set/Clear Aliases

This block is a bank of 32-bit control words for power management. Several bus masters share it. Each word sits on a 4-byte stride and is read or written as a whole word over a one-request-per-cycle register bus. Every request receives a response one cycle later, carrying an error flag and the read data.

Inside the low offset region (0x0000 to 0x3FFF), address bits 15 and 14 select an alias operation on a write. When they are `11`, the write sets one bit of the target register. When they are `10`, the write clears one bit. The bit number comes from the low five bits of the write data. Because only that one bit changes, masters that work on different bits of the same word never undo each other's updates, and none of them needs a read-modify-write sequence.

Writes into the low region need a secure qualifier. Reads are open to every master. A few words do not take part in aliasing:
- Two words in the low region accept plain writes only.
- Two words above 0x3FFF are writable by any master and have no alias behaviour.

Top module: `alias_regbank`

## Requirements
- R1: After an active-low synchronous reset, every register reads as zero, and no response is pending (`rspValid` low).
- R2: A request presented with `reqValid` high gets its response (`rspValid`, `rspError`, `rspRdata`) on the cycle after it is accepted. A plain write (address bits 15:14 = `00`) to a mapped word stores the full write data, and a later read returns that data. `reqReady` is always high.
- R3: A write with address bits 15:14 = `11` to one of the 16 aliased words (offsets 0x00 to 0x3C) sets bit `reqWdata[4:0]` of that word. All other bits of the word stay unchanged.
- R4: A write with address bits 15:14 = `10` to an aliased word clears bit `reqWdata[4:0]`. All other bits stay unchanged.
- R5: In an alias write, write data bits 31:5 have no effect on the result.
- R6: The plain-only words at offsets 0x100 and 0x104 accept plain writes. An alias write to them returns an error and leaves the word unchanged.
- R7: Any write with address bits 19:16 all zero and `reqSecure` low returns an error and changes nothing. The high words at 0x10000 and 0x10004 accept plain writes from non-secure masters.
- R8: Reads of mapped words need no secure qualifier, and return the current value with no error.
- R9: The following return an error with `rspRdata` zero, and change no register:
  - an access to an unmapped or misaligned offset;
  - a read whose address bits 15:14 are not `00`;
  - a write with address bits 15:14 = `01`;
  - an alias write to a high word.
- R10: Alias operations on different bits of the same word, issued on consecutive cycles, all take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present this cycle |
| reqReady | output | 1 | Request accepted (always high) |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | 20 | Byte address; bits 15:14 carry the alias operation in the low region |
| reqWdata | input | 32 | Write data, or bit number in bits 4:0 for alias writes |
| reqSecure | input | 1 | Secure-access qualifier |
| rspValid | output | 1 | Response valid, one cycle after the request |
| rspError | output | 1 | Request rejected |
| rspRdata | output | 32 | Read data; zero on error and for writes |

## Verification
Every request is driven at a falling edge and accepted at the next rising edge. At that same edge the register update and the registered response both happen, so the bench samples `rspValid`, `rspError` and `rspRdata` one time unit after that rising edge. A register's new value can therefore first be seen by a read issued in the following cycle. A reference model in the bench updates in request order, so a read that follows a write on the next cycle is predicted correctly. The same holds for runs of alias writes with no idle cycle between them.

// File: rtl/regbank_pkg.sv
package regbank_pkg;
  localparam int DATA_W     = 32;
  localparam int BIT_W      = $clog2(DATA_W);
  localparam int ALIAS_REGS = 16;
  localparam int EXCL_REGS  = 2;
  localparam int HIGH_REGS  = 2;
  localparam int NUM_REGS   = ALIAS_REGS + EXCL_REGS + HIGH_REGS;
  localparam int IDX_W      = $clog2(NUM_REGS);

  typedef struct packed {
    logic              wrEn;
    logic              setEn;
    logic              clrEn;
    logic              rdEn;
    logic [IDX_W-1:0]  idx;
    logic [BIT_W-1:0]  bitSel;
  } strobe_t;
endpackage

// File: rtl/regbank_ctrl.sv
module regbank_ctrl
  import regbank_pkg::*;
#(
  parameter int              ADDR_W    = 20,
  parameter logic [ADDR_W-1:0] EXCL_BASE = 'h100,
  parameter logic [ADDR_W-1:0] HIGH_BASE = 'h10000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [BIT_W-1:0]  reqBit,
  input  logic              reqSecure,
  output strobe_t           st,
  output logic              rspValid,
  output logic              rspError
);
  localparam logic [ADDR_W-1:0] LOW_END  = ADDR_W'(ALIAS_REGS * 4);
  localparam logic [ADDR_W-1:0] EXCL_END = EXCL_BASE + ADDR_W'(EXCL_REGS * 4);
  localparam logic [ADDR_W-1:0] HIGH_END = HIGH_BASE + ADDR_W'(HIGH_REGS * 4);
  localparam logic [ADDR_W-1:0] OP_MASK  = ADDR_W'(3) << 14;

  logic [1:0]        op;
  logic [ADDR_W-1:0] base, exclOff, highOff;
  logic              aligned, lowHit, exclHit, highHit;
  logic              plainHit, aliasHit, secOk, err;
  logic [IDX_W-1:0]  hitIdx;

  always_comb begin
    op       = reqAddr[15:14];
    base     = reqAddr & ~OP_MASK;
    aligned  = (reqAddr[1:0] == 2'b00);
    exclOff  = base - EXCL_BASE;
    highOff  = base - HIGH_BASE;
    lowHit   = aligned && (base < LOW_END);
    exclHit  = aligned && (base >= EXCL_BASE) && (base < EXCL_END);
    highHit  = aligned && (base >= HIGH_BASE) && (base < HIGH_END);
    plainHit = (op == 2'b00) && (lowHit || exclHit || highHit);
    aliasHit = op[1] && lowHit;
    secOk    = reqSecure || (reqAddr[ADDR_W-1:16] != '0);
    if (lowHit)       hitIdx = base[IDX_W+1:2];
    else if (exclHit) hitIdx = IDX_W'(ALIAS_REGS) + exclOff[IDX_W+1:2];
    else              hitIdx = IDX_W'(ALIAS_REGS + EXCL_REGS) + highOff[IDX_W+1:2];
  end

  always_comb begin
    st        = '0;
    err       = 1'b0;
    st.idx    = hitIdx;
    st.bitSel = reqBit;
    if (reqWrite) begin
      if (plainHit && secOk) begin
        st.wrEn = reqValid;
      end else if (aliasHit && secOk) begin
        st.setEn = reqValid & op[0];
        st.clrEn = reqValid & ~op[0];
      end else begin
        err = 1'b1;
      end
    end else begin
      if (plainHit) st.rdEn = reqValid;
      else          err = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspValid <= 1'b0;
      rspError <= 1'b0;
    end else begin
      rspValid <= reqValid;
      rspError <= reqValid & err;
    end
  end

  // R2
  rsp_follows_req_chk: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> rspValid);
  // R2
  no_spurious_rsp_chk: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> !rspValid);
  // R7
  nonsecure_low_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqWrite && !reqSecure && reqAddr[ADDR_W-1:16] == '0) |=> rspError);
  // R9
  alias_read_err_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !reqWrite && reqAddr[15]) |=> rspError);
endmodule

// File: rtl/regbank_dp.sv
module regbank_dp
  import regbank_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           st,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  logic [NUM_REGS-1:0][DATA_W-1:0] regs;
  logic [DATA_W-1:0]               targetVal;

  assign targetVal = regs[st.idx];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      regs  <= '0;
      rdata <= '0;
    end else begin
      if (st.wrEn)       regs[st.idx]            <= wdata;
      else if (st.setEn) regs[st.idx][st.bitSel] <= 1'b1;
      else if (st.clrEn) regs[st.idx][st.bitSel] <= 1'b0;
      rdata <= st.rdEn ? targetVal : '0;
    end
  end

  // R3
  set_bit_chk: assert property (@(posedge clk) disable iff (!rstN)
    st.setEn |=> regs[$past(st.idx)][$past(st.bitSel)]);
  // R4
  clr_bit_chk: assert property (@(posedge clk) disable iff (!rstN)
    st.clrEn |=> !regs[$past(st.idx)][$past(st.bitSel)]);
  // R5
  single_bit_change_chk: assert property (@(posedge clk) disable iff (!rstN)
    (st.setEn || st.clrEn) |=> ($countones(regs[$past(st.idx)] ^ $past(targetVal)) <= 1));
  // R6
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(st.wrEn || st.setEn || st.clrEn) |=> $stable(regs));
endmodule

// File: rtl/alias_regbank.sv
module alias_regbank
  import regbank_pkg::*;
#(
  parameter int                ADDR_W    = 20,
  parameter logic [ADDR_W-1:0] EXCL_BASE = 'h100,
  parameter logic [ADDR_W-1:0] HIGH_BASE = 'h10000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic              reqSecure,
  output logic              rspValid,
  output logic              rspError,
  output logic [DATA_W-1:0] rspRdata
);
  strobe_t st;

  assign reqReady = 1'b1;

  regbank_ctrl #(
    .ADDR_W(ADDR_W), .EXCL_BASE(EXCL_BASE), .HIGH_BASE(HIGH_BASE)
  ) ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .reqBit(reqWdata[BIT_W-1:0]), .reqSecure(reqSecure),
    .st(st), .rspValid(rspValid), .rspError(rspError)
  );

  regbank_dp dp (
    .clk(clk), .rstN(rstN), .st(st), .wdata(reqWdata), .rdata(rspRdata)
  );

  // R9
  err_zero_data_chk: assert property (@(posedge clk) disable iff (!rstN)
    rspError |-> (rspRdata == '0));
endmodule

// File: tb/alias_regbank_test.sv
`timescale 1ns/1ps
module alias_regbank_test;
  logic        clk = 1'b0;
  logic        rstN;
  logic        reqValid, reqWrite, reqSecure;
  logic        reqReady, rspValid, rspError;
  logic [19:0] reqAddr;
  logic [31:0] reqWdata, rspRdata;

  int   nChecks = 0;
  int   nFails  = 0;
  bit   done    = 1'b0;
  logic [31:0] mdl [20];

  always #2 clk = ~clk;

  alias_regbank uut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqWrite(reqWrite), .reqAddr(reqAddr), .reqWdata(reqWdata),
    .reqSecure(reqSecure), .rspValid(rspValid), .rspError(rspError),
    .rspRdata(rspRdata)
  );

  function automatic logic [19:0] addrOf(int k);
    if (k < 16)      return 20'(k * 4);
    else if (k < 18) return 20'h100 + 20'((k - 16) * 4);
    else             return 20'h10000 + 20'((k - 18) * 4);
  endfunction

  function automatic int regOf(logic [19:0] a);
    logic [19:0] b = a & 20'hF3FFF;
    if (a[1:0] != 2'b00) return -1;
    if (b < 20'h40) return int'(b) / 4;
    if (b >= 20'h100 && b < 20'h108) return 16 + int'(b - 20'h100) / 4;
    if (b >= 20'h10000 && b < 20'h10008) return 18 + int'(b - 20'h10000) / 4;
    return -1;
  endfunction

  task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic acc(bit wr, logic [19:0] a, logic [31:0] d, bit sec, string tag);
    int k = regOf(a);
    logic [1:0] op = a[15:14];
    bit expErr = 1'b0;
    logic [31:0] expData = '0;
    bit prot = (a[19:16] == 4'h0);
    if (wr) begin
      if (op == 2'b00 && k >= 0 && (sec || !prot)) mdl[k] = d;
      else if (op[1] && k >= 0 && k < 16 && sec) mdl[k][d[4:0]] = op[0];
      else expErr = 1'b1;
    end else begin
      if (op == 2'b00 && k >= 0) expData = mdl[k];
      else expErr = 1'b1;
    end
    @(negedge clk);
    reqValid = 1'b1; reqWrite = wr; reqAddr = a; reqWdata = d; reqSecure = sec;
    @(posedge clk);
    #1;
    nChecks++;
    if (rspValid !== 1'b1 || rspError !== expErr || rspRdata !== expData) begin
      nFails++;
      $display("FAIL %s addr %h: actual v=%b e=%b d=%h expected v=1 e=%b d=%h",
               tag, a, rspValid, rspError, rspRdata, expErr, expData);
    end
  endtask

  task automatic idle();
    @(negedge clk);
    reqValid = 1'b0;
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      nFails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < 20; i++) mdl[i] = '0;
    rstN = 1'b0; reqValid = 1'b0; reqWrite = 1'b0; reqAddr = '0;
    reqWdata = '0; reqSecure = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    // R1: no response pending during reset
    check("R1", "rspValid in reset", 32'(rspValid), 32'd0);
    @(negedge clk); rstN = 1'b1;
    // R1: every word reads zero after reset
    for (int k = 0; k < 20; k++) acc(0, addrOf(k), '0, 0, "R1");
    check("R2", "reqReady", 32'(reqReady), 32'd1);

    // R2: plain write and readback
    acc(1, 20'h4, 32'hDEADBEEF, 1, "R2");
    acc(0, 20'h4, '0, 0, "R2");
    // R3: set bit 7 of word 2
    acc(1, 20'hC008, 32'd7, 1, "R3");
    acc(0, 20'h8, '0, 0, "R3");
    // R4: clear bit 31 of word 1
    acc(1, 20'h8004, 32'd31, 1, "R4");
    acc(0, 20'h4, '0, 1, "R4");
    // R5: upper data bits ignored, bit 3 set
    acc(1, 20'hC008, 32'hFFFFFFE3, 1, "R5");
    acc(0, 20'h8, '0, 0, "R5");
    // R6: plain-only words
    acc(1, 20'h100, 32'h12345678, 1, "R6");
    acc(1, 20'hC100, 32'd0, 1, "R6");
    acc(1, 20'h8104, 32'd0, 1, "R6");
    acc(0, 20'h100, '0, 0, "R6");
    // R7: secure qualifier
    acc(1, 20'h8, 32'hFFFFFFFF, 0, "R7");
    acc(1, 20'hC00C, 32'd2, 0, "R7");
    acc(0, 20'h8, '0, 0, "R7");
    acc(1, 20'h10000, 32'hA5A5A5A5, 0, "R7");
    acc(0, 20'h10000, '0, 0, "R7");
    // R8: non-secure reads
    acc(0, 20'h104, '0, 0, "R8");
    acc(0, 20'h10004, '0, 0, "R8");
    // R9: unmapped, misaligned, bad op codes
    acc(0, 20'h200, '0, 1, "R9");
    acc(1, 20'h4000, 32'd1, 1, "R9");
    acc(0, 20'hC004, '0, 1, "R9");
    acc(1, 20'h6, 32'd5, 1, "R9");
    acc(1, 20'h1C000, 32'd1, 1, "R9");
    acc(0, 20'h10000, '0, 1, "R9");
    // R10: back-to-back alias updates to word 5
    acc(1, 20'hC014, 32'd0, 1, "R10");
    acc(1, 20'hC014, 32'd9, 1, "R10");
    acc(1, 20'hC014, 32'd30, 1, "R10");
    acc(1, 20'h8014, 32'd9, 1, "R10");
    acc(0, 20'h14, '0, 1, "R10");
    idle();

    // random mix checked against the model
    for (int n = 0; n < 4000; n++) begin
      int cls = int'($urandom % 6);
      logic [19:0] a;
      case (cls)
        0: a = addrOf(int'($urandom % 16)) | (20'($urandom % 4) << 14);
        1: a = addrOf(16 + int'($urandom % 2)) | (20'($urandom % 4) << 14);
        2: a = addrOf(18 + int'($urandom % 2)) | (20'($urandom % 4) << 14);
        3: a = 20'($urandom);
        default: a = addrOf(int'($urandom % 20));
      endcase
      acc(bit'($urandom % 2), a, $urandom, bit'($urandom % 4 != 0), "R3");
      if ($urandom % 8 == 0) idle();
    end
    idle();
    for (int k = 0; k < 20; k++) acc(0, addrOf(k), '0, 0, "R2");
    idle();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule